// File: doc/BRIEF.md
# Horizontal Polyphase Line Scaler

This block resamples one line of single-channel pixels along the horizontal axis. The line arrives over a valid/ready stream that ends with a last flag. The block holds it in a small capture stage and then produces a programmable number of output pixels, also over a valid/ready stream with a last flag. A fixed-point position accumulator, with 24 fraction bits, starts at a programmable initial position and advances by the scale ratio after every output pixel. The integer part of the position picks the source pixels under the filter. The top six fraction bits pick one of 64 filter phases.

Coefficients are not stored inside the block. The block presents the current phase on a read port and takes four signed 1.12 coefficients back on the same cycle. The filter uses 1, 2 or 4 taps. Source indices that fall outside the line are filled either with the nearest edge pixel or with a programmable padding value. A bypass mode copies source pixels straight through.

Configuration inputs must stay constant while a line is being processed. A new line is accepted only after the previous output line has been fully delivered.

Top module: `hscale_poly`

## Requirements
- R1: After reset `out_valid` and `out_last` are low and `in_ready` is high.
- R2: `in_ready` is high only while a line is being captured. It drops in the cycle after the pixel flagged `in_last` is accepted. `out_valid` is never high while `in_ready` is high.
- R3: Output pixel k (counting from 0) uses the source position s = I + F/2^24 + k*ratio/2^24 - 1, where I is `cfg_init_int`, F is `cfg_init_frac` and ratio is `cfg_ratio` (2 integer and 24 fraction bits). The base index is floor(s). The filter phase is bits 23:18 of the fraction of s, and it appears on `coef_phase` when that pixel is computed.
- R4: With `cfg_taps_m1` = 0 (one tap), the output is the source pixel at the base index, unchanged.
- R5: With `cfg_taps_m1` = 1 (two taps), the sum is p[b]*c0 + p[b+1]*c1, where b is the base index and cN is bits [14N+13:14N] of `coef_data`.
- R6: With `cfg_taps_m1` = 3 (four taps), the sum is p[b-1]*c0 + p[b]*c1 + p[b+1]*c2 + p[b+2]*c3.
- R7: A filtered result is (sum + 2048) shifted right arithmetically by 12, then clamped to the range 0..255.
- R8: With `cfg_edge_rep` = 1, an index below 0 reads source pixel 0. An index at or beyond the effective width reads the last pixel inside the effective width.
- R9: With `cfg_edge_rep` = 0, any out-of-range index reads `cfg_pad`. If the effective width is 0, every index reads `cfg_pad`, whatever the mode.
- R10: The effective line width is the number of accepted pixels, capped at MAX_W, with bit 0 cleared. An odd trailing pixel therefore lies outside the line.
- R11: With `cfg_bypass` = 1, output k is the source pixel at index k, with the same out-of-range fill. Ratio, initial position and tap count are ignored.
- R12: Exactly `cfg_out_w` output pixels are delivered, and `out_last` is set on the final one. While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_valid` hold.
- R13: The accumulator restarts from the initial position for every line, so a second line with the same settings uses the same positions and phases.
- R14: `cfg_taps_m1` = 2 behaves exactly as two taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_taps_m1 | input | 2 | Tap count minus one (0, 1, 3; 2 acts as 1) |
| cfg_bypass | input | 1 | Copy source pixels directly |
| cfg_edge_rep | input | 1 | 1: replicate edge pixel, 0: use pad value |
| cfg_pad | input | PIX_W | Fill value for out-of-range taps |
| cfg_ratio | input | 26 | Step per output pixel, 2.24 unsigned |
| cfg_init_int | input | 2 | Initial position, integer part |
| cfg_init_frac | input | 24 | Initial position, fraction part |
| cfg_out_w | input | OCW | Output pixels per line |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts input |
| in_data | input | PIX_W | Input pixel |
| in_last | input | 1 | Last pixel of input line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts output |
| out_data | output | PIX_W | Output pixel |
| out_last | output | 1 | Last pixel of output line |
| coef_phase | output | 6 | Phase presented to coefficient store |
| coef_data | input | 4*COEF_W | Four signed 1.12 coefficients for that phase |

## Verification
Ramps, alternating extremes and sparse patterns are sent through every tap count.

- The ramps reveal any index or phase offset, because each source position produces a distinct value.
- The 0/255 pattern with four taps pushes the sum above 255 and below 0, so a missing clamp or a rounding error becomes visible.
- Starting positions below zero and output counts longer than the line exercise both fill modes. An odd-length line shows whether the trailing pixel is correctly left outside the range.
- Back-to-back lines under a stalling consumer show whether the accumulator is reloaded for each line and whether the output handshake holds its data while stalled.

// File: rtl/hscale_pkg.sv
// Shared constants and types for the horizontal polyphase line scaler.
package hscale_pkg;
    localparam int FRAC_W    = 24;   // fraction bits of position and ratio
    localparam int PHASE_W   = 6;    // 64 filter phases
    localparam int COEF_W    = 14;   // signed 1.12 coefficient
    localparam int COEF_FRAC = 12;
    localparam int N_LANES   = 4;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_EMIT = 1'b1
    } hs_state_e;

    typedef enum logic [1:0] {
        TAPS_ONE  = 2'd0,
        TAPS_TWO  = 2'd1,
        TAPS_TWOB = 2'd2,
        TAPS_FOUR = 2'd3
    } hs_taps_e;
endpackage

// File: rtl/hs_line_store.sv
// Capture stage: stores one input line and serves four neighbouring taps
// around a signed base index, applying edge replication or padding.
// Assumes writes and reads never overlap (top-level sequencing).
module hs_line_store #(
    parameter int PIX_W = 8,
    parameter int MAX_W = 32,
    parameter int IDX_W = 10,
    parameter int LANES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_last,
    input  logic [PIX_W-1:0]              wr_data,
    input  logic                          edge_rep,
    input  logic [PIX_W-1:0]              pad,
    input  logic signed [IDX_W-1:0]       rd_base,
    output logic [LANES-1:0][PIX_W-1:0]   rd_pix
);
    localparam int AW    = $clog2(MAX_W);
    localparam int PTR_W = $clog2(MAX_W + 1);

    logic [PIX_W-1:0] pix [MAX_W];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] w_eff;
    logic [PTR_W-1:0] cnt_now;

    // Pixel count including the word being written, saturated at MAX_W.
    always_comb begin
        cnt_now = (wr_ptr == PTR_W'(MAX_W)) ? PTR_W'(MAX_W) : wr_ptr + 1'b1;
    end

    // Pointer and effective-width bookkeeping (width forced even).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            w_eff  <= '0;
        end else if (wr_en) begin
            if (wr_last) begin
                wr_ptr <= '0;
                w_eff  <= cnt_now & ~PTR_W'(1);
            end else begin
                wr_ptr <= cnt_now;
            end
        end
    end

    // Pixel storage; data only, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en && (wr_ptr < PTR_W'(MAX_W))) begin
            pix[wr_ptr[AW-1:0]] <= wr_data;
        end
    end

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            localparam logic signed [IDX_W-1:0] OFF = IDX_W'(j - 1);
            logic signed [IDX_W-1:0] li;
            logic signed [IDX_W-1:0] wlim;
            logic [PTR_W-1:0]        last_idx;
            // Resolve this lane's index against the line boundaries.
            always_comb begin
                li       = rd_base + OFF;
                wlim     = IDX_W'(w_eff);
                last_idx = w_eff - 1'b1;
                if (li >= 0 && li < wlim) begin
                    rd_pix[j] = pix[li[AW-1:0]];
                end else if (edge_rep && w_eff != '0) begin
                    rd_pix[j] = (li < 0) ? pix[0] : pix[last_idx[AW-1:0]];
                end else begin
                    rd_pix[j] = pad;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/hs_phase_acc.sv
// Position accumulator: loads the initial position, steps by the ratio,
// and reports floor(position - 1) with the 6-bit filter phase.
module hs_phase_acc #(
    parameter int AIW    = 9,
    parameter int FRAC_W = 24,
    parameter int PH_W   = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    step,
    input  logic [1:0]              init_int,
    input  logic [FRAC_W-1:0]       init_frac,
    input  logic [FRAC_W+1:0]       ratio,
    output logic signed [AIW:0]     base_idx,
    output logic [PH_W-1:0]         phase
);
    localparam int ACC_W = AIW + FRAC_W;
    localparam logic [ACC_W:0] ONE = (ACC_W+1)'(1) << FRAC_W;

    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   pos;

    // Load at line start, advance once per produced pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (load) begin
            acc <= {AIW'(init_int), init_frac};
        end else if (step) begin
            acc <= acc + ACC_W'(ratio);
        end
    end

    // Shift by one so that the default initial integer of 1 reads pixel 0.
    always_comb begin
        pos      = {1'b0, acc} - ONE;
        base_idx = pos[ACC_W:FRAC_W];
        phase    = pos[FRAC_W-1 -: PH_W];
    end
endmodule

// File: rtl/hs_tap_mac.sv
// Tap multiply-accumulate: weights up to four pixels by signed 1.12
// coefficients, rounds and clamps; one tap or bypass passes lane 1.
module hs_tap_mac #(
    parameter int PIX_W     = 8,
    parameter int COEF_W    = 14,
    parameter int COEF_FRAC = 12,
    parameter int LANES     = 4
) (
    input  logic [LANES-1:0][PIX_W-1:0]   pix,
    input  logic [LANES*COEF_W-1:0]       coef,
    input  logic [1:0]                    taps_m1,
    input  logic                          bypass,
    output logic [PIX_W-1:0]              result
);
    import hscale_pkg::*;
    localparam int SUM_W = PIX_W + COEF_W + 3;
    localparam logic signed [SUM_W-1:0] RND  = SUM_W'(1) <<< (COEF_FRAC - 1);
    localparam logic signed [SUM_W-1:0] PMAX = SUM_W'((1 << PIX_W) - 1);

    logic signed [SUM_W-1:0] prod_four [LANES];
    logic signed [SUM_W-1:0] prod_two  [2];
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] scaled;

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_four
            logic signed [COEF_W-1:0] cj;
            // Four-tap product: lane j pixel times coefficient j.
            always_comb begin
                cj           = coef[j*COEF_W +: COEF_W];
                prod_four[j] = SUM_W'(pix[j]) * SUM_W'(cj);
            end
        end
        for (genvar j = 0; j < 2; j++) begin : g_two
            logic signed [COEF_W-1:0] cj;
            // Two-tap product: pixel at base+j times coefficient j.
            always_comb begin
                cj          = coef[j*COEF_W +: COEF_W];
                prod_two[j] = SUM_W'(pix[j+1]) * SUM_W'(cj);
            end
        end
    endgenerate

    // Select sum by tap count, round, clamp to pixel range.
    always_comb begin
        if (hs_taps_e'(taps_m1) == TAPS_FOUR) begin
            sum = prod_four[0] + prod_four[1] + prod_four[2] + prod_four[3];
        end else begin
            sum = prod_two[0] + prod_two[1];
        end
        scaled = (sum + RND) >>> COEF_FRAC;
        if (bypass || hs_taps_e'(taps_m1) == TAPS_ONE) begin
            result = pix[1];
        end else if (scaled < 0) begin
            result = '0;
        end else if (scaled > PMAX) begin
            result = '1;
        end else begin
            result = scaled[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/hscale_poly.sv
// Horizontal polyphase line scaler top: captures a line, then emits
// cfg_out_w pixels under a valid/ready handshake. Config must be stable
// for the duration of a line.
module hscale_poly #(
    parameter int PIX_W   = 8,
    parameter int MAX_W   = 32,
    parameter int MAX_OUT = 64,
    parameter int COEF_W  = hscale_pkg::COEF_W,
    parameter int OCW     = $clog2(MAX_OUT + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [1:0]                         cfg_taps_m1,
    input  logic                               cfg_bypass,
    input  logic                               cfg_edge_rep,
    input  logic [PIX_W-1:0]                   cfg_pad,
    input  logic [hscale_pkg::FRAC_W+1:0]      cfg_ratio,
    input  logic [1:0]                         cfg_init_int,
    input  logic [hscale_pkg::FRAC_W-1:0]      cfg_init_frac,
    input  logic [OCW-1:0]                     cfg_out_w,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [PIX_W-1:0]                   in_data,
    input  logic                               in_last,
    output logic                               out_valid,
    input  logic                               out_ready,
    output logic [PIX_W-1:0]                   out_data,
    output logic                               out_last,
    output logic [hscale_pkg::PHASE_W-1:0]     coef_phase,
    input  logic [hscale_pkg::N_LANES*COEF_W-1:0] coef_data
);
    import hscale_pkg::*;
    localparam int AIW   = $clog2(MAX_W + 1) + 3;
    localparam int IDX_W = AIW + 1;

    hs_state_e                      state;
    logic [OCW-1:0]                 cnt;
    logic                           accept, fire, produce;
    logic signed [IDX_W-1:0]        acc_base, rd_base;
    logic [N_LANES-1:0][PIX_W-1:0]  taps;
    logic [PIX_W-1:0]               mac_out;

    assign in_ready = (state == ST_FILL);
    assign accept   = in_valid && in_ready;
    assign fire     = (state == ST_EMIT) && (!out_valid || out_ready);
    assign produce  = fire && (cnt < cfg_out_w);
    assign rd_base  = cfg_bypass ? IDX_W'(cnt) : acc_base;

    hs_line_store #(.PIX_W(PIX_W), .MAX_W(MAX_W), .IDX_W(IDX_W), .LANES(N_LANES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_last(in_last), .wr_data(in_data),
        .edge_rep(cfg_edge_rep), .pad(cfg_pad), .rd_base(rd_base), .rd_pix(taps)
    );

    hs_phase_acc #(.AIW(AIW), .FRAC_W(FRAC_W), .PH_W(PHASE_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .load(accept && in_last), .step(produce),
        .init_int(cfg_init_int), .init_frac(cfg_init_frac), .ratio(cfg_ratio),
        .base_idx(acc_base), .phase(coef_phase)
    );

    hs_tap_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .LANES(N_LANES)) u_mac (
        .pix(taps), .coef(coef_data), .taps_m1(cfg_taps_m1), .bypass(cfg_bypass),
        .result(mac_out)
    );

    // Line sequencing and registered output handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_FILL;
            cnt       <= '0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else if (state == ST_FILL) begin
            if (accept && in_last) begin
                state <= ST_EMIT;
                cnt   <= '0;
            end
        end else if (fire) begin
            if (produce) begin
                out_valid <= 1'b1;
                out_data  <= mac_out;
                out_last  <= (cnt == cfg_out_w - 1'b1);
                cnt       <= cnt + 1'b1;
            end else begin
                out_valid <= 1'b0;
                out_last  <= 1'b0;
                state     <= ST_FILL;
            end
        end
    end
endmodule

// File: rtl/hscale_poly_chk.sv
// Protocol checker for hscale_poly, attached by bind.
module hscale_poly_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_last,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_data,
    input logic             out_last
);
    // R2: no output while a line is being captured.
    a_r2_no_out_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);
    // R2: capture closes after the last input pixel.
    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);
    // R12: stalled output holds.
    a_r12_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
    // R12: last flag only with valid data.
    a_r12_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

bind hscale_poly hscale_poly_chk #(.PIX_W(PIX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/tb_hscale_poly.sv
module tb_hscale_poly;
    localparam int PIX_W = 8;
    localparam int OCW   = 7;
    localparam int CW    = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]  cfg_taps_m1 = '0;
    logic        cfg_bypass = 1'b0, cfg_edge_rep = 1'b1;
    logic [7:0]  cfg_pad = '0;
    logic [25:0] cfg_ratio = 26'(1 << 24);
    logic [1:0]  cfg_init_int = 2'd1;
    logic [23:0] cfg_init_frac = '0;
    logic [OCW-1:0] cfg_out_w = '0;
    logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
    logic [7:0] in_data = '0;
    logic in_ready, out_valid, out_last;
    logic [7:0] out_data;
    logic [5:0] coef_phase;
    logic [4*CW-1:0] coef_data;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int line [32];
    int n_in = 0;

    always #2 clk = ~clk;

    hscale_poly dut (
        .clk(clk), .rst_n(rst_n), .cfg_taps_m1(cfg_taps_m1), .cfg_bypass(cfg_bypass),
        .cfg_edge_rep(cfg_edge_rep), .cfg_pad(cfg_pad), .cfg_ratio(cfg_ratio),
        .cfg_init_int(cfg_init_int), .cfg_init_frac(cfg_init_frac), .cfg_out_w(cfg_out_w),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .coef_phase(coef_phase), .coef_data(coef_data)
    );

    // Coefficient store model: four lanes per phase, each phase sums to 4096.
    function automatic int cf(int ph, int l);
        case (l)
            0: return -(ph * 4);
            1: return 4096 - ph * 60;
            2: return ph * 62;
            default: return ph * 2;
        endcase
    endfunction

    always_comb begin
        for (int l = 0; l < 4; l++) coef_data[l*CW +: CW] = CW'(cf(int'(coef_phase), l));
    end

    function automatic int weff();
        int w = (n_in > 32) ? 32 : n_in;
        return w & ~1;
    endfunction

    function automatic int px(int j);
        int w = weff();
        if (j >= 0 && j < w) return line[j];
        if (cfg_edge_rep && w != 0) return (j < 0) ? line[0] : line[w-1];
        return int'(cfg_pad);
    endfunction

    function automatic int ref_pix(int k);
        longint s;
        int b, ph, sum, r;
        if (cfg_bypass) return px(k);
        s  = longint'(cfg_init_int) * 64'sd16777216 + longint'(cfg_init_frac)
             + longint'(k) * longint'(cfg_ratio) - 64'sd16777216;
        b  = int'(s >>> 24);
        ph = int'((s >>> 18) & 63);
        if (cfg_taps_m1 == 2'd0) return px(b);
        if (cfg_taps_m1 == 2'd3)
            sum = px(b-1)*cf(ph,0) + px(b)*cf(ph,1) + px(b+1)*cf(ph,2) + px(b+2)*cf(ph,3);
        else
            sum = px(b)*cf(ph,0) + px(b+1)*cf(ph,1);
        r = (sum + 2048) >>> 12;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic send_line(int n);
        n_in = n;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'(line[i]);
            in_last  = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic collect(string tag, bit stall);
        int k = 0, guard = 0;
        bit done = 1'b0;
        while (!done && guard < 3000) begin
            @(negedge clk);
            guard++;
            out_ready = stall ? ((guard % 3) != 0) : 1'b1;
            if (out_valid && out_ready) begin
                chk({tag, " data"}, int'(out_data), ref_pix(k));
                chk("R12 last flag", int'(out_last), int'(k == int'(cfg_out_w) - 1));
                k++;
                if (out_last) done = 1'b1;
            end
        end
        chk("R12 output count", k, int'(cfg_out_w));
        @(negedge clk);
        out_ready = 1'b1;
    endtask

    task automatic cfg(int taps, bit byp, bit rep, int pad, int ratio, int ii, int fr, int ow);
        cfg_taps_m1 = 2'(taps); cfg_bypass = byp; cfg_edge_rep = rep; cfg_pad = 8'(pad);
        cfg_ratio = 26'(ratio); cfg_init_int = 2'(ii); cfg_init_frac = 24'(fr);
        cfg_out_w = OCW'(ow);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out_last", int'(out_last), 0);
        chk("R1 in_ready", int'(in_ready), 1);
    endtask

    task automatic t_bypass();
        for (int i = 0; i < 10; i++) line[i] = 20 + i * 7;
        cfg(3, 1, 1, 0, 3 << 23, 2, 12345, 12);
        send_line(10);
        chk("R2 ready after last", int'(in_ready), 0);
        collect("R11 bypass", 0);
    endtask

    task automatic t_one_tap();
        for (int i = 0; i < 16; i++) line[i] = 200 - i * 9;
        cfg(0, 0, 1, 0, 2 << 24, 1, 0, 8);
        send_line(16);
        collect("R4 R3 one tap", 1);
    endtask

    task automatic t_two_tap();
        for (int i = 0; i < 12; i++) line[i] = (i * 37) % 251;
        cfg(1, 0, 1, 0, 24'h6A5A5A, 1, 0, 20);
        send_line(12);
        collect("R5 R8 two tap", 0);
    endtask

    task automatic t_four_pad();
        for (int i = 0; i < 16; i++) line[i] = ((i % 4) == 1 || (i % 4) == 2) ? 255 : 0;
        cfg(3, 0, 0, 8'h40, 24'hC00000, 1, 0, 22);
        send_line(16);
        collect("R6 R7 R9 four tap pad", 1);
    endtask

    task automatic t_four_rep();
        for (int i = 0; i < 14; i++) line[i] = 10 + i * 15;
        cfg(3, 0, 1, 8'h99, 24'hA3D70A, 0, 24'h800000, 18);
        send_line(14);
        collect("R6 R8 R3 four tap edge", 0);
    endtask

    task automatic t_odd_width();
        for (int i = 0; i < 11; i++) line[i] = 5 + i * 20;
        cfg(0, 0, 1, 0, 1 << 24, 1, 0, 12);
        send_line(11);
        collect("R10 odd width", 0);
    endtask

    task automatic t_code2();
        for (int i = 0; i < 12; i++) line[i] = 255 - (i * 29) % 200;
        cfg(2, 0, 1, 0, 24'h555555, 1, 24'h123456, 24);
        send_line(12);
        collect("R14 code two", 0);
    endtask

    task automatic t_reload();
        for (int rep = 0; rep < 2; rep++) begin
            for (int i = 0; i < 12; i++) line[i] = (rep * 90 + i * 23) % 256;
            cfg(3, 0, 1, 0, 24'hB00000, 1, 24'h400000, 15);
            send_line(12);
            collect("R13 reload per line", 1);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got %0d expected below %0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass();
        t_one_tap();
        t_two_tap();
        t_four_pad();
        t_four_rep();
        t_odd_width();
        t_code2();
        t_reload();
        finish_run();
    end
endmodule